// File: doc/BRIEF.md
# Setup Frame Destination Address Filter

This block decides, for every received frame, whether its destination address belongs to a station address table. The table has fourteen entries of six octets. Software loads it by streaming a 128-byte setup frame into the block, one byte per cycle. The first byte of that frame is marked by a start strobe.

The setup frame is made of two 64-byte halves laid out as eight octet rows of eight columns. The byte at offset `k` lies in half `k/64`, row `(k%64)/8` and column `k%8`. Columns 1 to 7 of rows 0 to 5 carry octet `row` of one entry each. Column 0 and rows 6 and 7 carry no data.

On the receive side, the block compares the first six bytes after a start-of-frame against all fourteen entries in parallel. It pulses a decision, pass or drop, in the cycle after the sixth byte. The broadcast address has no special handling; it passes only when it has been loaded as an entry. A setup frame that stops early is reported through a sticky flag and changes only the bytes that actually arrived.

Top module: `setup_addr_filter`

## Requirements
- R1: A setup byte at offset k (counting `setupValid` bytes from the one with `setupStart`, which is offset 0) whose column k%8 is 1 to 7 and whose row (k%64)/8 is 0 to 5 is stored as octet `row` (octet 0 = first byte on the wire) of entry (k/64)*7 + column - 1.
- R2: After reset no entry is active, and every received frame gets a drop decision (`decValid`=1, `decPass`=0); `shortSetup` is 0.
- R3: An entry becomes active when its octet 5 is stored and stays active until reset; after a complete 128-byte setup frame all fourteen entries are active.
- R4: `decValid` is high for exactly one cycle, the cycle after the sixth receive byte (the byte with `rxSof` is byte one) is presented with `rxValid`. `decPass` is then 1 exactly when some active entry equals the six bytes in order.
- R5: Cycles with `rxValid` low are not counted. Bytes after the sixth are ignored and give no further decision until the next `rxSof`. An `rxSof` in the middle of an address restarts the count at byte one.
- R6: The all-ones address passes only when it is stored in an active entry; there is no separate broadcast acceptance.
- R7: A setup frame cut short leaves every entry byte it did not reach unchanged. `shortSetup` is set when `setupStart` arrives before the previous frame reached 128 bytes, and cleared when a frame completes all 128 bytes.
- R8: Setup bytes in column 0 or in rows 6 and 7 change no entry, whatever their value.
- R9: `setupValid` bytes without `setupStart`, after a frame has completed, change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| setupValid | input | 1 | Setup byte present this cycle |
| setupStart | input | 1 | Marks the first byte of a setup frame |
| setupByte | input | 8 | Setup frame byte |
| rxValid | input | 1 | Receive byte present this cycle |
| rxSof | input | 1 | Marks the first byte of a received frame |
| rxByte | input | 8 | Received frame byte |
| decValid | output | 1 | One-cycle pulse: decision available |
| decPass | output | 1 | Decision: 1 accept, 0 drop (meaningful with decValid) |
| shortSetup | output | 1 | Sticky: last abandoned setup frame was short |

## Verification
Destination addresses are sent in several forms: exact copies of the first and last entries, the broadcast address, an unknown address, and near misses that differ only in the first or only in the last octet. These tell a full six-octet compare apart from a partial one. Addresses are also sent with idle gaps between bytes, with trailing payload, and with an aborted start followed by a restart, which separates byte counting from cycle counting. Three setup loads probe the storage: one full load with junk in the unused cells, one half-length load with different addresses, and one full reload. Together they distinguish the column and row mapping, the half-to-entry offset, partial-load retention and the short flag, and show that the broadcast address is accepted only while it is loaded.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  localparam int OCTETS      = 6;
  localparam int PER_HALF    = 7;
  localparam int NUM_ENTRIES = 2 * PER_HALF;
  localparam int ROWS        = 8;
  localparam int COLS        = 8;
  localparam int FRAME_LEN   = 2 * ROWS * COLS;
  localparam int ENT_W       = $clog2(NUM_ENTRIES);
  localparam int ROW_W       = $clog2(ROWS);
  localparam int CNT_W       = $clog2(FRAME_LEN);

  typedef struct packed {
    logic             wrEn;
    logic [ENT_W-1:0] wrEntry;
    logic [ROW_W-1:0] wrOctet;
    logic             cmpEn;
    logic             cmpFirst;
    logic [ROW_W-1:0] cmpOctet;
    logic             decide;
  } filtStrobes_t;
endpackage

// File: rtl/filt_ctrl.sv
module filt_ctrl
  import addr_filt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         setupValid,
  input  logic         setupStart,
  input  logic         rxValid,
  input  logic         rxSof,
  output filtStrobes_t strobes,
  output logic         shortSetup
);
  logic [CNT_W-1:0] setupCnt;
  logic             loading;
  logic [CNT_W-1:0] offs;
  logic             setupAcc;
  logic [ROW_W-1:0] rowIdx, colIdx;
  logic             halfIdx;
  logic [ROW_W-1:0] rxCnt;
  logic             rxActive;

  assign setupAcc = setupValid && (setupStart || loading);
  assign offs     = setupStart ? '0 : setupCnt;
  assign halfIdx  = offs[CNT_W-1];
  assign rowIdx   = offs[CNT_W-2 -: ROW_W];
  assign colIdx   = offs[ROW_W-1:0];

  always_comb begin
    strobes          = '0;
    strobes.wrEn     = setupAcc && (colIdx != '0) && (rowIdx < ROW_W'(OCTETS));
    strobes.wrEntry  = halfIdx ? (ENT_W'(colIdx) + ENT_W'(PER_HALF - 1))
                               : (ENT_W'(colIdx) - ENT_W'(1));
    strobes.wrOctet  = rowIdx;
    strobes.cmpEn    = rxValid && (rxSof || rxActive);
    strobes.cmpFirst = rxSof;
    strobes.cmpOctet = rxSof ? '0 : rxCnt;
    strobes.decide   = strobes.cmpEn && (strobes.cmpOctet == ROW_W'(OCTETS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setupCnt   <= '0;
      loading    <= 1'b0;
      shortSetup <= 1'b0;
    end else if (setupValid) begin
      if (setupStart) begin
        if (loading) shortSetup <= 1'b1;
        loading  <= 1'b1;
        setupCnt <= CNT_W'(1);
      end else if (loading) begin
        setupCnt <= setupCnt + CNT_W'(1);
        if (setupCnt == CNT_W'(FRAME_LEN - 1)) begin
          loading    <= 1'b0;
          shortSetup <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCnt    <= '0;
      rxActive <= 1'b0;
    end else if (rxValid) begin
      if (rxSof) begin
        rxActive <= 1'b1;
        rxCnt    <= ROW_W'(1);
      end else if (rxActive) begin
        rxCnt <= rxCnt + ROW_W'(1);
        if (rxCnt == ROW_W'(OCTETS - 1)) rxActive <= 1'b0;
      end
    end
  end

  AST_LOAD_CNT: assert property (@(posedge clk) disable iff (!rstN)
    loading |-> (setupCnt != '0)); // R1
  AST_RX_CNT: assert property (@(posedge clk) disable iff (!rstN)
    rxActive |-> (rxCnt != '0) && (rxCnt < ROW_W'(OCTETS))); // R5
  AST_SHORT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shortSetup) |-> $past(setupValid && setupStart)); // R7
endmodule

// File: rtl/filt_dpath.sv
module filt_dpath
  import addr_filt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  filtStrobes_t strobes,
  input  logic [7:0]   setupByte,
  input  logic [7:0]   rxByte,
  output logic         decValid,
  output logic         decPass
);
  logic [NUM_ENTRIES-1:0] entryValid;
  logic [NUM_ENTRIES-1:0] hit;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [7:0] oct [OCTETS];
    logic       vld;
    logic       hitR;
    logic [7:0] sel;
    logic       entSel;

    assign entSel = strobes.wrEn && (strobes.wrEntry == ENT_W'(e));

    for (genvar o = 0; o < OCTETS; o++) begin : g_oct
      always_ff @(posedge clk) begin
        if (entSel && (strobes.wrOctet == ROW_W'(o))) oct[o] <= setupByte;
      end
    end

    always_comb begin
      sel = '0;
      for (int o = 0; o < OCTETS; o++) begin
        if (strobes.cmpOctet == ROW_W'(o)) sel = oct[o];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld  <= 1'b0;
        hitR <= 1'b0;
      end else begin
        if (entSel && (strobes.wrOctet == ROW_W'(OCTETS - 1))) vld <= 1'b1;
        if (strobes.cmpEn) begin
          if (strobes.cmpFirst) hitR <= vld && (sel == rxByte);
          else                  hitR <= hitR && (sel == rxByte);
        end
      end
    end

    assign entryValid[e] = vld;
    assign hit[e]        = hitR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) decValid <= 1'b0;
    else       decValid <= strobes.decide;
  end

  assign decPass = decValid && (|hit);

  AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (entryValid == '0) |-> !decPass); // R2
  AST_DEC_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid); // R4
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((~entryValid & $past(entryValid)) == '0)); // R3
endmodule

// File: rtl/setup_addr_filter.sv
module setup_addr_filter
  import addr_filt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       setupValid,
  input  logic       setupStart,
  input  logic [7:0] setupByte,
  input  logic       rxValid,
  input  logic       rxSof,
  input  logic [7:0] rxByte,
  output logic       decValid,
  output logic       decPass,
  output logic       shortSetup
);
  filtStrobes_t strobes;

  filt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .setupValid (setupValid),
    .setupStart (setupStart),
    .rxValid    (rxValid),
    .rxSof      (rxSof),
    .strobes    (strobes),
    .shortSetup (shortSetup)
  );

  filt_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .setupByte (setupByte),
    .rxByte    (rxByte),
    .decValid  (decValid),
    .decPass   (decPass)
  );

  AST_DEC_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(rxValid)); // R4
endmodule

// File: tb/setup_addr_filter_tb.sv
`timescale 1ns/1ps
module setup_addr_filter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setupValid = 1'b0, setupStart = 1'b0;
  logic [7:0] setupByte = '0;
  logic rxValid = 1'b0, rxSof = 1'b0;
  logic [7:0] rxByte = '0;
  logic decValid, decPass, shortSetup;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [47:0] tbEnt [14];
  bit          tbVal [14];
  logic [47:0] cur   [14];
  bit          expQ  [$];
  string       tagQ  [$];

  always #2.5 clk = ~clk;

  setup_addr_filter u_dut (
    .clk(clk), .rstN(rstN),
    .setupValid(setupValid), .setupStart(setupStart), .setupByte(setupByte),
    .rxValid(rxValid), .rxSof(rxSof), .rxByte(rxByte),
    .decValid(decValid), .decPass(decPass), .shortSetup(shortSetup)
  );

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Streams the first nBytes of a setup frame built from cur[], updating the model.
  task automatic loadSetup(input int nBytes, input bit junk);
    for (int k = 0; k < nBytes; k++) begin
      int half, r, c, idx;
      logic [7:0] b;
      half = k / 64; r = (k % 64) / 8; c = k % 8;
      if (c != 0 && r < 6) begin
        idx = half * 7 + c - 1;
        b = cur[idx][47 - 8*r -: 8];
        tbEnt[idx][47 - 8*r -: 8] = b;
        if (r == 5) tbVal[idx] = 1;
      end else begin
        b = junk ? (8'h5A ^ 8'(k)) : 8'h00;
      end
      @(negedge clk);
      setupValid = 1'b1; setupStart = (k == 0); setupByte = b;
    end
    @(negedge clk);
    setupValid = 1'b0; setupStart = 1'b0;
  endtask

  task automatic sendRx(input logic [47:0] da, input bit gaps, input int extra, input string req);
    bit exp;
    exp = 0;
    for (int i = 0; i < 14; i++) if (tbVal[i] && tbEnt[i] === da) exp = 1;
    expQ.push_back(exp);
    tagQ.push_back(req);
    for (int j = 0; j < 6; j++) begin
      if (gaps && (j == 2 || j == 4)) begin
        @(negedge clk); rxValid = 1'b0; rxSof = 1'b0;
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
      rxValid = 1'b1; rxSof = (j == 0); rxByte = da[47 - 8*j -: 8];
    end
    for (int j = 0; j < extra; j++) begin
      @(negedge clk); rxValid = 1'b1; rxSof = 1'b0; rxByte = da[47 -: 8] ^ 8'(j);
    end
    @(negedge clk); rxValid = 1'b0; rxSof = 1'b0;
    idle(3);
  endtask

  // Monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rstN && decValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R5: unexpected decision actual=1 expected=0");
      end else begin
        bit e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (decPass !== e) begin
          errors++;
          $display("FAIL %s: decPass actual=%0b expected=%0b", t, decPass, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 14; i++) begin tbEnt[i] = '0; tbVal[i] = 0; end
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    checkBit("R2 reset decValid", decValid, 1'b0);
    checkBit("R2 reset shortSetup", shortSetup, 1'b0);

    // R2: nothing loaded -> drop
    sendRx(48'hFFFF_FFFF_FFFF, 0, 0, "R2 empty broadcast");
    sendRx(48'h0000_0000_0000, 0, 0, "R2 empty zero");

    // Set A: full load with junk in unused cells (R1, R3, R8)
    for (int i = 0; i < 14; i++) cur[i] = 48'h0800_2BAA_BB00 + 48'(i);
    cur[5] = 48'hFFFF_FFFF_FFFF;
    loadSetup(128, 1);
    idle(2);
    checkBit("R7 full load no short", shortSetup, 1'b0);
    sendRx(cur[0], 0, 0, "R1 entry0");
    sendRx(cur[13], 1, 0, "R1 entry13 gaps R5");
    sendRx(cur[7], 0, 4, "R1 entry7 trailing R5");
    sendRx(48'hFFFF_FFFF_FFFF, 0, 0, "R6 broadcast loaded");
    sendRx(48'h0800_2BAA_BB00 + 48'd14, 0, 0, "R4 last octet miss");
    sendRx(48'h0900_2BAA_BB03, 0, 0, "R4 first octet miss");
    sendRx(48'h5A5A_5A5A_5A5A, 0, 0, "R8 junk not stored");
    sendRx(48'h0000_0000_0000, 0, 0, "R8 zero not stored");

    // Set B: short load of first half, then a lone start byte (R7)
    for (int i = 0; i < 14; i++) cur[i] = 48'h0800_2BCC_0000 + 48'(i);
    loadSetup(64, 0);
    @(negedge clk); setupValid = 1'b1; setupStart = 1'b1; setupByte = 8'hEE;
    @(negedge clk); setupValid = 1'b0; setupStart = 1'b0;
    idle(1);
    checkBit("R7 short flag set", shortSetup, 1'b1);
    sendRx(cur[0], 0, 0, "R7 new first half");
    sendRx(48'h0800_2BAA_BB00, 0, 0, "R7 old first half replaced");
    sendRx(48'h0800_2BAA_BB00 + 48'd8, 0, 0, "R7 old second half kept");
    sendRx(cur[8], 0, 0, "R7 second half not written");
    sendRx(48'hFFFF_FFFF_FFFF, 1, 0, "R6 broadcast removed");

    // Set C: full reload clears flag (R3, R7)
    for (int i = 0; i < 14; i++) cur[i] = 48'h0A0B_0C0D_0E00 + 48'(i * 3);
    loadSetup(128, 0);
    idle(1);
    checkBit("R7 short flag cleared", shortSetup, 1'b0);
    sendRx(cur[6], 0, 0, "R3 entry6");
    sendRx(cur[12], 0, 0, "R3 entry12");

    // R9: stray setup bytes without start
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); setupValid = 1'b1; setupStart = 1'b0; setupByte = 8'hFF;
    end
    @(negedge clk); setupValid = 1'b0;
    idle(1);
    checkBit("R9 stray bytes no short", shortSetup, 1'b0);
    sendRx(cur[1], 0, 0, "R9 entry1 intact");
    sendRx(48'hFFFF_FFFF_FFFF, 0, 0, "R9 no broadcast written");

    // R5: aborted address then restart
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); rxValid = 1'b1; rxSof = (j == 0); rxByte = 8'h0A + 8'(j);
    end
    sendRx(cur[9], 0, 2, "R5 restart");
    sendRx(48'h0A0B_0C0D_0E01, 0, 0, "R4 near miss");

    idle(5);
    checkBit("R4 scoreboard drained", expQ.size() == 0, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule